// File: doc/BRIEF.md
# Windowed Burst Register Access Controller

This block holds a bank of word-spaced 16-bit registers behind a simple register bus and adds a single window address. A configuration register chooses a starting register (the window base) and a beat count. Each access to the window address is steered to the register at window base plus a running beat index. The index then moves on by one. This lets a DMA engine with a fixed peripheral address scatter a buffer into a run of consecutive registers, or gather a run of registers into a buffer.

An update event arms a burst while the update-DMA enable input is high. The block then holds its DMA request high until the window has been accessed once for every beat of the burst. The next update event arms a fresh burst from index 0, so a long buffer refills the same registers once per event.

Top module: `burst_regwin`

## Requirements
- R1: After reset, `dma_req` is low, the configuration register reads 0x0000 and the beat index is 0, so the first window access reaches the register at the window base.
- R2: The configuration register sits at byte address 4*NREG (0x80 by default). Bits 12:8 hold the beat-count code and bits 4:0 the window base. Bits 15:13 and 7:5 always read as zero.
- R3: A beat-count code written above 17 is stored as 17. A code n gives n+1 beats, so the range is 1 to 18 beats.
- R4: Bank register k sits at byte address 4*k for k below NREG. A read returns its data on `bus_rdata` in the cycle after the read is accepted. Addresses that decode to nothing read as zero.
- R5: An access to the window address (byte address 4*NREG+4, 0x84 by default) acts on the bank register at word base+index, which is byte address 4*(base+index). Each window access moves the index up by one. The access made at index equal to the code returns the index to 0.
- R6: An update event starts a burst only while `upd_dma_en` is high and no burst is running. `dma_req` then rises in the cycle after the event.
- R7: `dma_req` stays high until the window has been accessed once per beat, and it is low in the cycle after the last beat.
- R8: A second update event after a finished burst starts again at index 0 and reaches the same registers as the first burst.
- R9: Writing the configuration register cancels any running burst: `dma_req` goes low and the index returns to 0.
- R10: When base+index is NREG or more, a window read returns zero and a window write changes no register, but the index still advances.
- R11: An update event that arrives during a running burst is ignored. The burst keeps its index and its remaining beat count.
- R12: All data through the bank and the window is 16 bits wide, and every bit is stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read |
| upd_evt | input | 1 | Update event pulse |
| upd_dma_en | input | 1 | Enables burst start on update events |
| dma_req | output | 1 | DMA request, high while the burst has beats left |

## Verification
A DMA-like loop serves each request with random window reads and writes under random base and beat-count settings, including codes above the cap. Comparing the results with a bench model separates a wrong base+index sum from wrong index wrap and from an early or late drop of the request. Idle window accesses between bursts test whether the index also advances without a request. Directed runs cover the rest: a burst that starts near the top of the bank and runs past it, a configuration write in the middle of a burst, an update event during a burst, and an event with the enable low. Each of these tells apart a behaviour that the random traffic seldom reaches.

// File: rtl/burst_regwin_pkg.sv
package burst_regwin_pkg;
  localparam int unsigned FIELD_W = 5;

  typedef struct packed {
    logic [FIELD_W-1:0] len;
    logic [FIELD_W-1:0] base;
  } win_cfg_t;

  function automatic logic [15:0] cfg_to_word(win_cfg_t c);
    return {3'b000, c.len, 3'b000, c.base};
  endfunction
endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_regwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [FIELD_W-1:0] cfg_len,
  input  logic               win_acc,
  input  logic               upd_evt,
  input  logic               upd_en,
  output logic [FIELD_W-1:0] idx,
  output logic               active
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      active <= 1'b0;
    end else if (cfg_wr) begin
      idx    <= '0;
      active <= 1'b0;
    end else begin
      if (win_acc) begin
        if (idx == cfg_len) begin
          idx    <= '0;
          active <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (upd_evt && upd_en && !active) begin
        active <= 1'b1;
        idx    <= '0;
      end
    end
  end

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    idx <= cfg_len);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    active && !win_acc && !cfg_wr |=> active);
  assert_last_beat_R7: assert property (@(posedge clk) disable iff (rst)
    active && win_acc && !cfg_wr && (idx == cfg_len) |=> !active && (idx == '0));
  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !active && (idx == '0));
  assert_start_gate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(upd_evt && upd_en));
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
    active && !win_acc && !cfg_wr |=> $stable(idx));
endmodule

// File: rtl/burst_dec.sv
module burst_dec
  import burst_regwin_pkg::*;
#(
  parameter int unsigned NREG   = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned EFF_W  = 6
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] base,
  input  logic [FIELD_W-1:0] idx,
  output logic               is_ctrl,
  output logic               is_win,
  output logic               bank_hit,
  output logic [EFF_W-1:0]   eff_word
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;

  always_comb begin
    word    = addr[ADDR_W-1:2];
    is_ctrl = (int'(word) == NREG);
    is_win  = (int'(word) == NREG + 1);
    if (is_win) eff_word = EFF_W'(base) + EFF_W'(idx);
    else        eff_word = EFF_W'(word);
    bank_hit = (int'(eff_word) < NREG);
  end
endmodule

// File: rtl/burst_regbank.sv
module burst_regbank #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [$clog2(NREG)-1:0] raddr,
  output logic [DATA_W-1:0]       rdata
);
  logic [DATA_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/burst_regwin.sv
module burst_regwin
  import burst_regwin_pkg::*;
#(
  parameter int unsigned NREG    = 32,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned MAX_LEN = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              upd_evt,
  input  logic              upd_dma_en,
  output logic              dma_req
);
  localparam int unsigned RIDX_W = $clog2(NREG);
  localparam int unsigned EFF_W  = (ADDR_W - 2 > FIELD_W + 1) ? ADDR_W - 2 : FIELD_W + 1;

  win_cfg_t           cfg;
  logic [FIELD_W-1:0] idx;
  logic               is_ctrl, is_win, bank_hit;
  logic [EFF_W-1:0]   eff_word;
  logic               cfg_wr, win_acc, bank_we;
  logic [FIELD_W-1:0] len_in;
  logic [DATA_W-1:0]  mem_rdata;
  logic               rd_bank_q, rd_ctrl_q;
  logic [15:0]        ctrl_q;

  burst_dec #(.NREG(NREG), .ADDR_W(ADDR_W), .EFF_W(EFF_W)) u_dec (
    .addr(bus_addr), .base(cfg.base), .idx(idx),
    .is_ctrl(is_ctrl), .is_win(is_win), .bank_hit(bank_hit), .eff_word(eff_word)
  );

  assign cfg_wr  = bus_en && bus_we && is_ctrl;
  assign win_acc = bus_en && is_win;
  assign bank_we = bus_en && bus_we && bank_hit && !is_ctrl;
  assign len_in  = (int'(bus_wdata[12:8]) > MAX_LEN) ? FIELD_W'(MAX_LEN) : bus_wdata[12:8];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      cfg.len  <= len_in;
      cfg.base <= bus_wdata[4:0];
    end
  end

  burst_seq u_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_len(cfg.len), .win_acc(win_acc),
    .upd_evt(upd_evt), .upd_en(upd_dma_en), .idx(idx), .active(dma_req)
  );

  burst_regbank #(.NREG(NREG), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .we(bank_we), .waddr(eff_word[RIDX_W-1:0]), .wdata(bus_wdata),
    .raddr(eff_word[RIDX_W-1:0]), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bank_q <= 1'b0;
      rd_ctrl_q <= 1'b0;
      ctrl_q    <= '0;
    end else begin
      rd_bank_q <= bus_en && !bus_we && bank_hit && !is_ctrl;
      rd_ctrl_q <= bus_en && !bus_we && is_ctrl;
      ctrl_q    <= cfg_to_word(cfg);
    end
  end

  always_comb begin
    if (rd_bank_q)      bus_rdata = mem_rdata;
    else if (rd_ctrl_q) bus_rdata = DATA_W'(ctrl_q);
    else                bus_rdata = '0;
  end

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (rst)
    int'(cfg.len) <= MAX_LEN);
  assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    rd_ctrl_q |-> (bus_rdata[15:13] == 3'b000) && (bus_rdata[7:5] == 3'b000));
endmodule

// File: tb/burst_regwin_bench.sv
module burst_regwin_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;
  localparam int CTRL_W = NREG;
  localparam int WIN_W = NREG + 1;

  logic clk = 0, rst = 1;
  logic bus_en = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic upd_evt = 0, upd_dma_en = 0, dma_req;

  int checks = 0, errors = 0;
  logic [15:0] m_mem [NREG];
  int m_base = 0, m_len = 0, m_idx = 0;
  bit m_act = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_regwin u_burst_regwin (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_evt(upd_evt),
    .upd_dma_en(upd_dma_en), .dma_req(dma_req)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(int word);
    int eff;
    if (word < NREG) return m_mem[word];
    if (word == CTRL_W) return 16'(m_len << 8) | 16'(m_base);
    if (word == WIN_W) begin
      eff = m_base + m_idx;
      return (eff < NREG) ? m_mem[eff] : 16'h0;
    end
    return 16'h0;
  endfunction

  task automatic acc(bit we, int word, logic [15:0] wd, string req, bit do_chk);
    logic [15:0] exp, rd;
    int eff, l;
    exp = exp_rd(word);
    @(negedge clk);
    bus_en = 1; bus_we = we; bus_addr = 8'(word * 4); bus_wdata = wd;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    rd = bus_rdata;
    if (we) begin
      if (word < NREG) m_mem[word] = wd;
      else if (word == CTRL_W) begin
        l = int'(wd[12:8]);
        m_len = (l > 17) ? 17 : l;
        m_base = int'(wd[4:0]);
        m_idx = 0; m_act = 0;
      end
    end
    if (word == WIN_W) begin
      eff = m_base + m_idx;
      if (we && eff < NREG) m_mem[eff] = wd;
      if (m_idx == m_len) begin m_idx = 0; m_act = 0; end
      else m_idx++;
    end
    if (!we && do_chk) chk(rd == exp, req, rd, exp);
    if (do_chk) chk(dma_req == m_act, {req, " dma_req"}, dma_req, m_act);
  endtask

  task automatic pulse(bit en, string req);
    @(negedge clk);
    upd_evt = 1; upd_dma_en = en;
    @(negedge clk);
    upd_evt = 0;
    if (en && !m_act) begin m_act = 1; m_idx = 0; end
    chk(dma_req == m_act, req, dma_req, m_act);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < NREG; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(dma_req == 0, "R1 req", dma_req, 0);
    acc(0, CTRL_W, 0, "R1 ctrl", 1);
    for (int i = 0; i < NREG; i++) acc(1, i, 16'(i * 16'h0101 + 16'h00A5), "R4", 0);
    acc(0, WIN_W, 0, "R1 win at base", 1);
    // R4 / R12 direct access, full width
    acc(1, 5, 16'hFFFF, "R12", 0);
    acc(0, 5, 0, "R12 all ones", 1);
    acc(0, 9, 0, "R4 direct", 1);
    acc(0, 40, 0, "R4 unmapped zero", 1);
    // R2 / R3 layout and cap: write 0xFFFF reads 0x111F
    acc(1, CTRL_W, 16'hFFFF, "R2", 0);
    acc(0, CTRL_W, 0, "R2 R3 layout", 1);
    chk(exp_rd(CTRL_W) == 16'h111F, "R3 model", exp_rd(CTRL_W), 16'h111F);
    // R5 R7 R8: base 14, code 2 -> 3 beats, twice
    acc(1, CTRL_W, 16'h020E, "R5", 0);
    pulse(0, "R6 disabled");
    pulse(1, "R6 start");
    for (int b = 0; b < 3; b++) acc(1, WIN_W, 16'h1000 + 16'(b), "R7 beat", 1);
    chk(dma_req == 0, "R7 end", dma_req, 0);
    pulse(1, "R8 restart");
    for (int b = 0; b < 3; b++) acc(1, WIN_W, 16'h2000 + 16'(b), "R8 beat", 1);
    for (int b = 14; b < 17; b++) acc(0, b, 0, "R8 same regs", 1);
    // R11 update during burst
    pulse(1, "R11 start");
    acc(0, WIN_W, 0, "R11 beat", 1);
    pulse(1, "R11 ignored");
    acc(0, WIN_W, 0, "R11 beat", 1);
    acc(0, WIN_W, 0, "R11 last", 1);
    // R9 abort
    pulse(1, "R9 start");
    acc(0, WIN_W, 0, "R9 beat", 1);
    acc(1, CTRL_W, 16'h0303, "R9 abort", 1);
    acc(0, WIN_W, 0, "R9 index cleared", 1);
    // R10 past end: base 30, code 3
    acc(1, CTRL_W, 16'h031E, "R10", 0);
    pulse(1, "R10 start");
    acc(1, WIN_W, 16'hBEE0, "R10 beat", 1);
    acc(1, WIN_W, 16'hBEE1, "R10 beat", 1);
    acc(1, WIN_W, 16'hDEAD, "R10 oor write", 1);
    acc(0, WIN_W, 0, "R10 oor read", 1);
    acc(0, 0, 0, "R10 no alias", 1);
    acc(0, 1, 0, "R10 no alias", 1);
    acc(0, 31, 0, "R10 last reg", 1);
    // random traffic
    for (int t = 0; t < 300; t++) begin
      v = 16'($urandom);
      acc(1, CTRL_W, {3'b0, 5'($urandom_range(0, 20)), 3'b0, 5'($urandom)}, "R3 rand", 0);
      acc(0, CTRL_W, 0, "R2 rand", 1);
      pulse(1'($urandom_range(0, 3) != 0), "R6 rand");
      while (dma_req) acc(1'($urandom), WIN_W, 16'($urandom), "R5 rand", 1);
      if ($urandom_range(0, 1)) acc(1'($urandom), WIN_W, v, "R5 idle", 1);
      acc(0, int'($urandom_range(0, NREG - 1)), 0, "R4 rand", 1);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule